// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block serves a bank of general-purpose I/O pins. Each pin owns a small group of memory-mapped registers: a direction control, a data register that returns the synchronized pin level and holds the drive value, an interrupt configuration word, and a sticky status bit. Each pin input passes through a two-flop synchronizer. Detection logic then turns the synchronized level into a per-pin trigger, either on one edge or on one level, as the configuration selects.

Two independent controls act on a trigger. One decides whether the sticky status bit records it. The other decides whether it can raise an interrupt at all. A separate per-pin routing code chooses which processor receives the pin's interrupt. One registered summary line goes high while any pin routed to the main processor has an enabled, active request. Software finds the source by reading the status bits and clears each one by writing a one to it.

The register bus is a single-cycle interface. A write is committed on the clock edge where the write enable is high. Read data is a combinational function of the address and of the current register contents.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `pin_oe`, `pin_out` and `irq_summary` are low, and the bank has no pending interrupt.
- R2: Pin i's register group sits at 0x1000 + 0x10*i. At offset +0x0, bit 9 is the output enable and drives `pin_oe[i]`. At offset +0x4, bit 1 holds the drive value on `pin_out[i]`, and bit 0 reads the input level two clock edges after it reaches the synchronizer. A read of an address outside the map, or of one that is not word aligned, returns zero.
- R3: The interrupt configuration word sits at +0x8. When its bit 2 is 1, detection is by edge. Bit 1 then picks the edge: 1 for rising, 0 for falling. Each matching edge sets the status bit once, and a steady level never sets it again.
- R4: When bit 2 of the configuration is 0, detection is by level. Bit 1 picks the active level: 1 for high, 0 for low. The status bit is set while the level is active. When the level is still active, the status bit sets again on the cycle after a clear.
- R5: Bit 3 of the configuration enables status recording. While it is 0, no trigger sets the status bit.
- R6: Status bit 0 at +0xC clears when 1 is written to it. Writing 0 leaves it unchanged. A clear and a trigger in the same cycle leave the bit cleared.
- R7: Bit 0 of the configuration enables the interrupt. A pin has a pending interrupt only when this bit is 1. The pending source is the status bit when recording is enabled, and the live trigger when it is not.
- R8: Pin i's routing register sits at 0x400 + 4*i, with the code in bits 2:0. Only code 4 (main processor) lets the pin's pending interrupt reach `irq_summary`. Any other code, including 7 (no target), blocks it.
- R9: `irq_summary` is registered. It follows, one clock edge later, whether any pin routed with code 4 has a pending interrupt.
- R10: With recording disabled and the interrupt enabled, a single edge in edge mode holds `irq_summary` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write enable; the write commits on this edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_summary | output | 1 | Interrupt to the main processor |

## Verification
The clear of a status bit and the setting of that bit by a new edge can fall on the same clock edge. The bench forces this overlap by counting synchronizer stages from the cycle where the pin changes, then placing the write-one-to-clear so that it commits on the exact edge that would record the trigger. The result is judged by reading the status bit afterwards: it must be zero, and it must stay zero because the level is steady. The level-mode case is exercised the same way: the bit reads zero right after the clear and one a cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int PIN_IDX_W = 8;

    localparam logic [ADDR_W-1:0] BANK_BASE  = 16'h1000;
    localparam logic [ADDR_W-1:0] ROUTE_BASE = 16'h0400;
    localparam int GROUP_STRIDE = 16;
    localparam int ROUTE_STRIDE = 4;

    localparam int OE_BIT   = 9;
    localparam int LVL_BIT  = 0;
    localparam int OUT_BIT  = 1;
    localparam int STAT_BIT = 0;
    localparam int ICFG_W   = 4;
    localparam int ROUTE_W  = 3;

    localparam logic [ROUTE_W-1:0] ROUTE_MAIN = 3'd4;
    localparam logic [ROUTE_W-1:0] ROUTE_NONE = 3'd7;

    // bit 3 raw_en, bit 2 edge_mode, bit 1 pol_high, bit 0 int_en
    typedef struct packed {
        logic raw_en;
        logic edge_mode;
        logic pol_high;
        logic int_en;
    } icfg_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CFG,
        REG_IO,
        REG_ICFG,
        REG_STAT,
        REG_ROUTE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e            kind;
        logic [PIN_IDX_W-1:0] pin;
    } reg_sel_t;

    typedef struct packed {
        logic               oe;
        logic               out;
        logic               lvl;
        icfg_t              icfg;
        logic               status;
        logic [ROUTE_W-1:0] route;
    } pin_view_t;

    typedef struct packed {
        logic               oe;
        logic               out;
        icfg_t              icfg;
        logic               clr;
        logic [ROUTE_W-1:0] route;
    } wr_fields_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a, input int n);
        reg_sel_t s;
        logic [ADDR_W-1:0] off;
        s.kind = REG_NONE;
        s.pin  = '0;
        off    = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= BANK_BASE && a < BANK_BASE + 16'(GROUP_STRIDE * n)) begin
                off   = a - BANK_BASE;
                s.pin = PIN_IDX_W'(off >> 4);
                case (2'(off >> 2))
                    2'd0:    s.kind = REG_CFG;
                    2'd1:    s.kind = REG_IO;
                    2'd2:    s.kind = REG_ICFG;
                    default: s.kind = REG_STAT;
                endcase
            end else if (a >= ROUTE_BASE && a < ROUTE_BASE + 16'(ROUTE_STRIDE * n)) begin
                off    = a - ROUTE_BASE;
                s.pin  = PIN_IDX_W'(off >> 2);
                s.kind = REG_ROUTE;
            end
        end
        return s;
    endfunction

    function automatic logic trigger_of(input icfg_t c, input logic lvl, input logic prev);
        logic t;
        if (c.edge_mode)
            t = c.pol_high ? (lvl & ~prev) : (~lvl & prev);
        else
            t = c.pol_high ? lvl : ~lvl;
        return t;
    endfunction

    function automatic logic [DATA_W-1:0] read_word(input pin_view_t v, input reg_kind_e k);
        logic [DATA_W-1:0] w;
        w = '0;
        case (k)
            REG_CFG:   w[OE_BIT] = v.oe;
            REG_IO: begin
                w[LVL_BIT] = v.lvl;
                w[OUT_BIT] = v.out;
            end
            REG_ICFG:  w[ICFG_W-1:0] = v.icfg;
            REG_STAT:  w[STAT_BIT] = v.status;
            REG_ROUTE: w[ROUTE_W-1:0] = v.route;
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] lvl,
    output logic [NUM_PINS-1:0] prev
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign prev = prev_q;

    // R3: a rise seen by the edge detector lasts a single cycle on each pin
    assert_edge_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        ((lvl_q & ~prev_q) != '0) |=> (((lvl_q & ~prev_q) & $past(lvl_q & ~prev_q)) == '0));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  logic       prev,
    input  logic       wr_cfg,
    input  logic       wr_io,
    input  logic       wr_icfg,
    input  logic       wr_stat,
    input  logic       wr_route,
    input  wr_fields_t wf,
    output pin_view_t  view,
    output logic       pending,
    output logic       route_main
);
    logic               oe_q;
    logic               out_q;
    icfg_t              icfg_q;
    logic               status_q;
    logic [ROUTE_W-1:0] route_q;
    logic               trig;
    logic               clr_now;

    assign trig    = trigger_of(icfg_q, lvl, prev);
    assign clr_now = wr_stat & wf.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            icfg_q  <= '0;
            route_q <= '0;
        end else begin
            if (wr_cfg)   oe_q    <= wf.oe;
            if (wr_io)    out_q   <= wf.out;
            if (wr_icfg)  icfg_q  <= wf.icfg;
            if (wr_route) route_q <= wf.route;
        end
    end

    // clear has priority over a trigger in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else if (clr_now)
            status_q <= 1'b0;
        else if (icfg_q.raw_en && trig)
            status_q <= 1'b1;
    end

    always_comb begin
        if (!icfg_q.int_en)
            pending = 1'b0;
        else if (icfg_q.raw_en)
            pending = status_q;
        else
            pending = trig;
    end

    assign route_main = (route_q == ROUTE_MAIN);

    assign view.oe     = oe_q;
    assign view.out    = out_q;
    assign view.lvl    = lvl;
    assign view.icfg   = icfg_q;
    assign view.status = status_q;
    assign view.route  = route_q;

    // R5: with recording off, a clear status bit stays clear
    assert_no_record_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!icfg_q.raw_en && !status_q) |=> !status_q);

    // R6: a write of one to the status bit leaves it clear on the next cycle
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        clr_now |=> !status_q);

    // R6: writing zero to the status bit keeps a set bit set
    assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !wf.clr && status_q) |=> status_q);

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pending,
    input  logic [NUM_PINS-1:0] route_main,
    output logic                irq
);
    logic [NUM_PINS-1:0] req;
    logic                irq_q;

    assign req = pending & route_main;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |req;
    end

    assign irq = irq_q;

    // R8: without a routed pending request the summary line falls
    assert_unrouted_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> !irq_q);

    // R9: a routed pending request raises the summary one edge later
    assert_summary_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> irq_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_summary
);
    reg_sel_t            sel;
    wr_fields_t          wf;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] prev;
    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] route_main;
    pin_view_t           views [NUM_PINS];
    logic                unused_wdata;

    assign sel = decode(bus_addr, NUM_PINS);

    assign wf.oe    = bus_wdata[OE_BIT];
    assign wf.out   = bus_wdata[OUT_BIT];
    assign wf.icfg  = bus_wdata[ICFG_W-1:0];
    assign wf.clr   = bus_wdata[STAT_BIT];
    assign wf.route = bus_wdata[ROUTE_W-1:0];
    assign unused_wdata = ^{bus_wdata[31:10], bus_wdata[8:4]};

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .lvl    (lvl),
        .prev   (prev)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic hit;
        assign hit = bus_we && (sel.pin == PIN_IDX_W'(i));

        gpio_pin_slice u_slice (
            .clk        (clk),
            .rst        (rst),
            .lvl        (lvl[i]),
            .prev       (prev[i]),
            .wr_cfg     (hit && sel.kind == REG_CFG),
            .wr_io      (hit && sel.kind == REG_IO),
            .wr_icfg    (hit && sel.kind == REG_ICFG),
            .wr_stat    (hit && sel.kind == REG_STAT),
            .wr_route   (hit && sel.kind == REG_ROUTE),
            .wf         (wf),
            .view       (views[i]),
            .pending    (pending[i]),
            .route_main (route_main[i])
        );

        assign pin_out[i] = views[i].out;
        assign pin_oe[i]  = views[i].oe;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel.kind != REG_NONE && sel.pin == PIN_IDX_W'(i))
                bus_rdata = read_word(views[i], sel.kind);
        end
    end

    gpio_irq_summary #(.NUM_PINS(NUM_PINS)) u_summary (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .route_main (route_main),
        .irq        (irq_summary)
    );

    // R1: the summary line is low in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq_summary);

endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_summary(irq)
    );

    function automatic logic [15:0] grp(input int p, input int r);
        return 16'h1000 + 16'(p * 16 + r * 4);
    endfunction
    function automatic logic [15:0] rte(input int p);
        return 16'h0400 + 16'(p * 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(grp(0, 2), d); check("R1 icfg after reset", d, 0);
        rd(grp(3, 0), d); check("R1 cfg after reset", d, 0);
        check("R1 summary after reset", {31'd0, irq}, 0);
        check("R1 oe/out after reset", {16'd0, pin_oe, pin_out}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(grp(2, 0), 32'h200);
        check("R2 pin_oe from cfg bit 9", {24'd0, pin_oe}, 32'h04);
        rd(grp(2, 0), d); check("R2 cfg readback", d, 32'h200);
        wr(grp(2, 1), 32'h2);
        check("R2 pin_out from io bit 1", {24'd0, pin_out}, 32'h04);
        pin_in[3] = 1'b1;
        wait_cyc(1);
        rd(grp(3, 1), d); check("R2 input not yet through synchronizer", d, 0);
        wait_cyc(2);
        rd(grp(3, 1), d); check("R2 io bit 0 reads level", d, 32'h1);
        rd(grp(N, 0), d); check("R2 unmapped pin group reads zero", d, 0);
        rd(16'h1002, d); check("R2 unaligned address reads zero", d, 0);
        pin_in[3] = 1'b0;
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(grp(1, 2), 32'hE);
        pin_in[1] = 1'b1;
        wait_cyc(4);
        rd(grp(1, 3), d); check("R3 rising edge sets status", d, 1);
        wr(grp(1, 3), 32'h1);
        wait_cyc(3);
        rd(grp(1, 3), d); check("R3 steady high does not retrigger", d, 0);
        wr(grp(1, 2), 32'hC);
        wait_cyc(2);
        rd(grp(1, 3), d); check("R3 config change while steady", d, 0);
        pin_in[1] = 1'b0;
        wait_cyc(4);
        rd(grp(1, 3), d); check("R3 falling edge sets status", d, 1);
        wr(grp(1, 3), 32'h0);
        rd(grp(1, 3), d); check("R6 writing zero keeps status", d, 1);
        wr(grp(1, 3), 32'h1);
        rd(grp(1, 3), d); check("R6 writing one clears status", d, 0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(grp(4, 2), 32'hA);
        wait_cyc(3);
        rd(grp(4, 3), d); check("R4 inactive low level", d, 0);
        pin_in[4] = 1'b1;
        wait_cyc(4);
        rd(grp(4, 3), d); check("R4 active high level sets status", d, 1);
        wr(grp(4, 3), 32'h1);
        rd(grp(4, 3), d); check("R4 status clear on write cycle", d, 0);
        wait_cyc(1);
        rd(grp(4, 3), d); check("R4 status sets again next cycle", d, 1);
        wr(grp(4, 2), 32'h8);
        wr(grp(4, 3), 32'h1);
        wait_cyc(3);
        rd(grp(4, 3), d); check("R4 low-active with high pin", d, 0);
        pin_in[4] = 1'b0;
        wait_cyc(4);
        rd(grp(4, 3), d); check("R4 low-active with low pin", d, 1);
    endtask

    task automatic t_rawdis;
        logic [31:0] d;
        int highs;
        wr(grp(5, 2), 32'h7);
        wr(rte(5), 32'h4);
        wait_cyc(2);
        check("R10 summary low before edge", {31'd0, irq}, 0);
        highs = 0;
        pin_in[5] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (irq) highs++;
        end
        check("R10 summary pulse length", highs, 1);
        rd(grp(5, 3), d); check("R5 no status with recording off", d, 0);
    endtask

    task automatic t_summary;
        logic [31:0] d;
        wr(grp(6, 2), 32'hE);
        wr(rte(6), 32'h7);
        pin_in[6] = 1'b1;
        wait_cyc(4);
        rd(grp(6, 3), d); check("R8 status set on unrouted pin", d, 1);
        check("R7 no summary with interrupt disabled", {31'd0, irq}, 0);
        wr(grp(6, 2), 32'hF);
        wait_cyc(2);
        check("R8 code 7 blocks summary", {31'd0, irq}, 0);
        wr(rte(6), 32'h4);
        check("R9 summary not yet high after route write", {31'd0, irq}, 0);
        wait_cyc(1);
        check("R9 summary high one edge later", {31'd0, irq}, 1);
        rd(rte(6), d); check("R8 route readback", d, 4);
        wr(grp(6, 2), 32'hE);
        wait_cyc(1);
        check("R7 disabling interrupt drops summary", {31'd0, irq}, 0);
        wr(grp(6, 2), 32'hF);
        wr(grp(6, 3), 32'h1);
        wait_cyc(2);
        check("R9 summary low after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(grp(7, 2), 32'hE);
        wait_cyc(1);
        pin_in[7] = 1'b1;   // status would be recorded on the third rising edge
        @(negedge clk);
        @(negedge clk);
        addr = grp(7, 3); wdata = 32'h1; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        rd(grp(7, 3), d); check("R6 clear beats same-cycle edge", d, 0);
        wait_cyc(3);
        rd(grp(7, 3), d); check("R6 lost edge stays lost", d, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_edge();
        t_level();
        t_rawdis();
        t_summary();
        t_collide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule